// File: doc/BRIEF.md
# Serial Address/Data Level Control Interface

This block is a serial slave that sets a bank of volume levels. It holds one master attenuation code and six channel gain codes. A host shifts 8-bit words in over a serial clock and a data line. A write-enable pin gates the shifting, and a separate load strobe commits each word. Every level change takes two words. The first is an address word, which has its top bit set and names a target. The second is a data word, which has its top bit clear and carries the new level. If the write-enable and load pins are tied together, the link becomes a three-wire interface.

The serial pins are asynchronous to the block. They are sampled by the system clock through a synchronizer, and their edges are detected in the system clock domain. For every channel the block also outputs a net level: the channel gain minus the master attenuation, as a two's-complement code. Downstream logic can use this code directly.

Top module: `serial_level_ctl`

## Requirements
- R1: A bit is taken from `sdata_i` on each falling edge of `sclk_i` while `wr_n_i` is low. Words are shifted in MSB first, and a committed word is the last 8 bits shifted in.
- R2: Falling edges of `sclk_i` while `wr_n_i` is high shift nothing and do not count toward the word.
- R3: A word takes effect only on a rising edge of `ld_n_i`, and only if exactly 8 bits were shifted since the previous rising edge. A frame of any other length is discarded and leaves every level unchanged.
- R4: A committed word with bit 7 = 1 is an address word, and its bits 2:0 select the target. Value 0 selects the master, and values 1 to 6 select channels 1 to 6. An address word with bits 2:0 = 7 has no effect, so any pending target stays pending.
- R5: A committed word with bit 7 = 0 is a data word. For the master target, bits 6:0 become the new attenuation code. For a channel target, bits 4:0 become the new gain code, and bits 6:5 are ignored.
- R6: A data word that arrives with no target pending is discarded. A data word that is applied clears the pending target, so a second data word without a new address has no effect.
- R7: An address word replaces any target that is already pending.
- R8: `chan_net_o[8n-1:8n-8]` for channel n (n = 1 to 6) is the 8-bit two's-complement value of the channel gain minus the master attenuation. Its range is −127 to +31.
- R9: After reset the master code is 127, every channel gain is 0, and no target is pending.
- R10: A level register changes at the third rising edge of `clk` that samples `ld_n_i` high after it was low, counting that first sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sdata_i | input | 1 | Serial data, MSB first |
| wr_n_i | input | 1 | Active-low shift enable (chip select) |
| ld_n_i | input | 1 | Load strobe; its rising edge commits the shifted word |
| master_att_o | output | 7 | Master attenuation code in dB |
| chan_gain_o | output | 30 | Six 5-bit channel gain codes; channel 1 in bits 4:0 |
| chan_net_o | output | 48 | Six 8-bit signed net levels; channel 1 in bits 7:0 |

## Verification
The bench sends frames of 7 and 9 bits. A design that counted loosely would commit a stale address or level from them. It sends address 7 between a valid address and its data word. A design that treated 7 as a real address, or cleared the pending target on it, would lose the update. The bench also sends data words with no address, or after an update has already used its address. A design that kept the target alive would write twice. Other tests interleave stray serial clocks while write-enable is high, send data words with the high bits set to a channel, and count the exact edge at which a load becomes visible. These catch designs that shift while deselected, that write too many bits into a channel, or that add or drop a pipeline stage.

// File: rtl/slc_pkg.sv
package slc_pkg;

  // Sampled view of the four serial pins
  typedef struct packed {
    logic sclk;
    logic sdata;
    logic wr_n;
    logic ld_n;
  } ser_pins_t;

  // Value the synchronizer holds during reset: no edge is seen on release
  localparam ser_pins_t PINS_IDLE = '{sclk: 1'b0, sdata: 1'b0, wr_n: 1'b1, ld_n: 1'b1};

endpackage

// File: rtl/slc_rst_sync.sv
module slc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/slc_serial_rx.sv
module slc_serial_rx
  import slc_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ser_pins_t         pins_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);

  localparam int              CNT_W    = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  ser_pins_t sync_q [SYNC_STAGES];
  ser_pins_t prev_q;
  ser_pins_t cur;

  logic              ld_rise;
  logic              sclk_fall;
  logic              shift_en;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  // Pin synchronizer plus one delayed copy for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= PINS_IDLE;
      prev_q <= PINS_IDLE;
    end else begin
      sync_q[0] <= pins_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= cur;
    end
  end

  assign cur       = sync_q[SYNC_STAGES-1];
  assign ld_rise   = !prev_q.ld_n && cur.ld_n;
  assign sclk_fall = prev_q.sclk && !cur.sclk;
  // Load wins over a coincident shift; shifting only while selected (R1, R2)
  assign shift_en  = sclk_fall && !cur.wr_n && !ld_rise;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (ld_rise) begin
      cnt_d = '0;
    end else if (shift_en) begin
      sh_d = {sh_q[WORD_W-2:0], cur.sdata};
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (shift_en)            sh_q  <= sh_d;
      if (shift_en || ld_rise) cnt_q <= cnt_d;
    end
  end

  // Only a frame of exactly WORD_W bits is handed on (R3)
  assign word_vld_o = ld_rise && (cnt_q == CNT_FULL);
  assign word_o     = sh_q;

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_SAT);

  assert_frame_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rise |=> (cnt_q == '0));

  assert_deselect_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && cur.wr_n) |=> $stable(sh_q));

endmodule

// File: rtl/slc_reg_bank.sv
module slc_reg_bank #(
  parameter int WORD_W = 8,
  parameter int ATT_W  = 7,
  parameter int GAIN_W = 5,
  parameter int NUM_CH = 6,
  parameter int SEL_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     word_vld_i,
  input  logic [WORD_W-1:0]        word_i,
  output logic [ATT_W-1:0]         master_o,
  output logic [NUM_CH*GAIN_W-1:0] gain_o
);

  localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(NUM_CH);

  logic             is_addr;
  logic [SEL_W-1:0] sel;
  logic             sel_ok;
  logic             apply;
  logic             pend_q, pend_d;
  logic [SEL_W-1:0] tgt_q, tgt_d;
  logic             master_we;
  logic [NUM_CH-1:0] chan_we;
  logic [ATT_W-1:0] master_q, master_d;

  assign is_addr = word_i[WORD_W-1];
  assign sel     = word_i[SEL_W-1:0];
  assign sel_ok  = (sel <= SEL_LAST);
  assign apply   = word_vld_i && !is_addr && pend_q;

  // Pending target: set by a valid address, kept on an out-of-range one,
  // cleared by any data word (R4, R6, R7)
  always_comb begin
    pend_d = pend_q;
    tgt_d  = tgt_q;
    if (word_vld_i) begin
      if (is_addr) begin
        if (sel_ok) begin
          pend_d = 1'b1;
          tgt_d  = sel;
        end
      end else begin
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tgt_q  <= '0;
    end else if (word_vld_i) begin
      pend_q <= pend_d;
      tgt_q  <= tgt_d;
    end
  end

  // Master attenuation register (R5, R9)
  assign master_we = apply && (tgt_q == '0);

  always_comb begin
    master_d = master_we ? word_i[ATT_W-1:0] : master_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= '1;
    end else if (master_we) begin
      master_q <= master_d;
    end
  end

  assign master_o = master_q;

  // Channel gain registers, low GAIN_W bits of the data word only (R5)
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic [GAIN_W-1:0] gain_q, gain_d;

    assign chan_we[g] = apply && (tgt_q == SEL_W'(g + 1));

    always_comb begin
      gain_d = chan_we[g] ? word_i[GAIN_W-1:0] : gain_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gain_q <= '0;
      end else if (chan_we[g]) begin
        gain_q <= gain_d;
      end
    end

    assign gain_o[g*GAIN_W +: GAIN_W] = gain_q;
  end

  assert_single_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chan_we, master_we}));

  assert_levels_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld_i |=> ($stable(master_o) && $stable(gain_o)));

  assert_data_consumes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_i && !is_addr) |=> !pend_q);

  assert_bad_addr_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_i && is_addr && !sel_ok) |=> ($stable(pend_q) && $stable(tgt_q)));

  assert_addr_arms_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_i && is_addr && sel_ok) |=> pend_q);

endmodule

// File: rtl/slc_net_calc.sv
module slc_net_calc #(
  parameter int ATT_W  = 7,
  parameter int GAIN_W = 5,
  parameter int NUM_CH = 6,
  parameter int NET_W  = 8
) (
  input  logic [ATT_W-1:0]         master_i,
  input  logic [NUM_CH*GAIN_W-1:0] gain_i,
  output logic [NUM_CH*NET_W-1:0]  net_o
);

  // Gain minus attenuation, wrapped into NET_W-bit two's complement (R8)
  for (genvar g = 0; g < NUM_CH; g++) begin : g_net
    assign net_o[g*NET_W +: NET_W] =
      NET_W'(gain_i[g*GAIN_W +: GAIN_W]) - NET_W'(master_i);
  end

endmodule

// File: rtl/serial_level_ctl.sv
module serial_level_ctl
  import slc_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int ATT_W       = 7,
  parameter int GAIN_W      = 5,
  parameter int NUM_CH      = 6,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int NET_W      = ((ATT_W > GAIN_W) ? ATT_W : GAIN_W) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk_i,
  input  logic                     sdata_i,
  input  logic                     wr_n_i,
  input  logic                     ld_n_i,
  output logic [ATT_W-1:0]         master_att_o,
  output logic [NUM_CH*GAIN_W-1:0] chan_gain_o,
  output logic [NUM_CH*NET_W-1:0]  chan_net_o
);

  localparam int NET_LO = -((1 << ATT_W) - 1);
  localparam int NET_HI = (1 << GAIN_W) - 1;

  logic              rst_sync_n;
  ser_pins_t         pins;
  logic              word_vld;
  logic [WORD_W-1:0] word;

  assign pins.sclk  = sclk_i;
  assign pins.sdata = sdata_i;
  assign pins.wr_n  = wr_n_i;
  assign pins.ld_n  = ld_n_i;

  slc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  slc_serial_rx #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pins_i     (pins),
    .word_vld_o (word_vld),
    .word_o     (word)
  );

  slc_reg_bank #(
    .WORD_W (WORD_W),
    .ATT_W  (ATT_W),
    .GAIN_W (GAIN_W),
    .NUM_CH (NUM_CH),
    .SEL_W  (SEL_W)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .word_vld_i (word_vld),
    .word_i     (word),
    .master_o   (master_att_o),
    .gain_o     (chan_gain_o)
  );

  slc_net_calc #(
    .ATT_W  (ATT_W),
    .GAIN_W (GAIN_W),
    .NUM_CH (NUM_CH),
    .NET_W  (NET_W)
  ) u_net (
    .master_i (master_att_o),
    .gain_i   (chan_gain_o),
    .net_o    (chan_net_o)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    assert_net_range_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (int'($signed(chan_net_o[g*NET_W +: NET_W])) >= NET_LO) &&
      (int'($signed(chan_net_o[g*NET_W +: NET_W])) <= NET_HI));
  end

endmodule

// File: tb/serial_level_ctl_tb.sv
`timescale 1ns/1ps
module serial_level_ctl_tb_top;

  localparam int SYNC = 2;
  localparam int NCH  = 6;
  localparam int H    = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sclk, sdata, wr_n, ld_n;
  logic [6:0]  master_att;
  logic [29:0] chan_gain;
  logic [47:0] chan_net;

  int    compared   = 0;
  int    mismatched = 0;
  int    cyc        = 0;
  bit    done       = 1'b0;
  string cur_req    = "R9";

  // Behavioural reference state
  int         m_master;
  int         m_gain [NCH];
  bit         m_pend;
  int         m_tgt;
  int         m_cnt;
  logic [7:0] m_sh;
  logic [3:0] hist [$];   // {sclk, sdata, wr_n, ld_n}, newest first

  always #2.5 clk = ~clk;

  serial_level_ctl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk_i       (sclk),
    .sdata_i      (sdata),
    .wr_n_i       (wr_n),
    .ld_n_i       (ld_n),
    .master_att_o (master_att),
    .chan_gain_o  (chan_gain),
    .chan_net_o   (chan_net)
  );

  function automatic int gain_of(int c);
    return int'(chan_gain[(c-1)*5 +: 5]);
  endfunction

  function automatic int net_of(int c);
    return int'($signed(chan_net[(c-1)*8 +: 8]));
  endfunction

  task automatic model_word(input logic [7:0] w);
    if (w[7]) begin
      if (w[2:0] <= 3'd6) begin
        m_pend = 1'b1;
        m_tgt  = int'(w[2:0]);
      end
    end else if (m_pend) begin
      if (m_tgt == 0) m_master = int'(w[6:0]);
      else            m_gain[m_tgt-1] = int'(w[4:0]);
      m_pend = 1'b0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_master = 127;
      foreach (m_gain[i]) m_gain[i] = 0;
      m_pend = 1'b0;
      m_tgt  = 0;
      m_cnt  = 0;
      m_sh   = 8'h00;
      hist   = {};
      for (int i = 0; i <= SYNC; i++) hist.push_back(4'b0011);
    end else begin
      logic [3:0] s, p;
      s = hist[SYNC-1];
      p = hist[SYNC];
      if (!p[0] && s[0]) begin
        if (m_cnt == 8) model_word(m_sh);
        m_cnt = 0;
      end else if (p[3] && !s[3] && !s[1]) begin
        m_sh = {m_sh[6:0], s[2]};
        if (m_cnt < 9) m_cnt++;
      end
      hist.push_front({sclk, sdata, wr_n, ld_n});
      void'(hist.pop_back());
    end
  end

  // Per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done && cyc > 2) begin
      string what;
      int    act, exp;
      bit    bad;
      bad = 1'b0;
      compared++;
      if (int'(master_att) != m_master) begin
        bad = 1'b1; what = "master"; act = int'(master_att); exp = m_master;
      end
      for (int c = 1; c <= NCH; c++) begin
        if (!bad && gain_of(c) != m_gain[c-1]) begin
          bad = 1'b1; what = $sformatf("gain ch%0d", c); act = gain_of(c); exp = m_gain[c-1];
        end
        if (!bad && net_of(c) != m_gain[c-1] - m_master) begin
          bad = 1'b1; what = $sformatf("net ch%0d", c); act = net_of(c);
          exp = m_gain[c-1] - m_master;
        end
      end
      if (bad) begin
        mismatched++;
        $display("FAIL %s cycle %0d %s: actual %0d expected %0d", cur_req, cyc, what, act, exp);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    sdata = b;
    sclk  = 1'b1;
    wait_clk(H);
    sclk  = 1'b0;
    wait_clk(H);
  endtask

  // Three-wire frame: write and load tied, n bits MSB first
  task automatic frame(input logic [15:0] bits, input int n);
    wr_n = 1'b0;
    ld_n = 1'b0;
    wait_clk(H);
    for (int i = n - 1; i >= 0; i--) put_bit(bits[i]);
    wait_clk(H);
    wr_n = 1'b1;
    ld_n = 1'b1;
    wait_clk(H * 3);
  endtask

  task automatic word(input logic [7:0] w);
    frame({8'h00, w}, 8);
  endtask

  initial begin
    rst_n = 1'b0;
    sclk  = 1'b0;
    sdata = 1'b0;
    wr_n  = 1'b1;
    ld_n  = 1'b1;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(6);

    // R9: reset state
    chk("R9 master after reset", int'(master_att), 127);
    for (int c = 1; c <= NCH; c++) chk("R9 gain after reset", gain_of(c), 0);
    chk("R9 net after reset", net_of(1), -127);
    word(8'h05);
    chk("R9 no pending after reset", int'(master_att), 127);

    // R1, R5: master write, MSB-first assembly
    cur_req = "R1";
    word(8'h80); word(8'h2A);
    chk("R1 R5 master code", int'(master_att), 42);

    // R4: every channel address
    cur_req = "R4";
    for (int c = 1; c <= NCH; c++) begin
      word(8'h80 | 8'(c));
      word(8'(c * 5));
      chk("R4 channel select", gain_of(c), c * 5);
    end
    chk("R8 net ch3", net_of(3), 15 - 42);

    // R5: bits above the gain field are ignored
    cur_req = "R5";
    word(8'h83); word(8'h7F);
    chk("R5 gain saturating field", gain_of(3), 31);
    word(8'h83); word(8'h65);
    chk("R5 high bits dropped", gain_of(3), 5);

    // R4: address 7 leaves the pending target alone
    cur_req = "R4";
    word(8'h82); word(8'h87); word(8'h09);
    chk("R4 address 7 ignored", gain_of(2), 9);

    // R6: orphan data and reuse of a spent address
    cur_req = "R6";
    word(8'h11);
    chk("R6 orphan data gain", gain_of(2), 9);
    chk("R6 orphan data master", int'(master_att), 42);
    word(8'h81); word(8'h0E);
    chk("R6 applied", gain_of(1), 14);
    word(8'h12);
    chk("R6 second data discarded", gain_of(1), 14);

    // R7: newer address wins
    cur_req = "R7";
    word(8'h81); word(8'h84); word(8'h0C);
    chk("R7 new target", gain_of(4), 12);
    chk("R7 old target untouched", gain_of(1), 14);

    // R3: wrong-length frames
    cur_req = "R3";
    frame(16'h0080, 9);
    word(8'h05);
    chk("R3 nine-bit frame dropped", int'(master_att), 42);
    word(8'h86);
    frame(16'h0040, 7);
    chk("R3 seven-bit frame dropped", gain_of(6), 30);
    word(8'h03);
    chk("R3 pending survives short frame", gain_of(6), 3);

    // R2: stray clocks while deselected (separate write and load)
    cur_req = "R2";
    word(8'h82);
    wr_n = 1'b0; ld_n = 1'b0;
    wait_clk(H);
    for (int i = 7; i >= 4; i--) put_bit(1'(8'h16 >> i));
    wr_n = 1'b1;
    wait_clk(H);
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    wr_n = 1'b0;
    wait_clk(H);
    for (int i = 3; i >= 0; i--) put_bit(1'(8'h16 >> i));
    wr_n = 1'b1;
    wait_clk(H);
    ld_n = 1'b1;
    wait_clk(H * 3);
    chk("R2 deselected clocks ignored", gain_of(2), 22);

    // R10: commit latency after the load edge
    cur_req = "R10";
    word(8'h85);
    wr_n = 1'b0; ld_n = 1'b0;
    wait_clk(H);
    for (int i = 7; i >= 0; i--) put_bit(1'(8'h0B >> i));
    wr_n = 1'b1;
    wait_clk(H * 2);
    ld_n = 1'b1;
    wait_clk(1);
    chk("R10 unchanged after 1st edge", gain_of(5), 25);
    wait_clk(1);
    chk("R10 unchanged after 2nd edge", gain_of(5), 25);
    wait_clk(1);
    chk("R10 updated after 3rd edge", gain_of(5), 11);
    wait_clk(H * 2);

    // R8: net level extremes
    cur_req = "R8";
    word(8'h80); word(8'h00);
    word(8'h86); word(8'h1F);
    chk("R8 net maximum", net_of(6), 31);
    word(8'h80); word(8'h7F);
    word(8'h86); word(8'h00);
    chk("R8 net minimum", net_of(6), -127);
    chk("R8 net ch2", net_of(2), 22 - 127);

    // R9: reset during operation
    cur_req = "R9";
    word(8'h80); word(8'h10);
    word(8'h84);
    rst_n = 1'b0;
    wait_clk(2);
    chk("R9 master on reset", int'(master_att), 127);
    chk("R9 gain on reset", gain_of(4), 0);
    rst_n = 1'b1;
    wait_clk(6);
    word(8'h07);
    chk("R9 pending cleared by reset", gain_of(4), 0);

    wait_clk(4);
    finish_run();
  end

endmodule